// File: doc/BRIEF.md
# Rotate-Through-Carry Shift Unit

This block is the rotate and shift execution stage of an 8/16-bit integer datapath. The decoder sets one valid cycle with the operand, a byte-or-word width select, a 3-bit operation code, a count source and the current flags. One clock later the unit presents the new destination value, a one-cycle write-enable and the six updated flags: carry, overflow, parity, zero, sign and auxiliary carry.

Seven operations are supported. Four are rotates: plain left, plain right, left through carry and right through carry. Three are shifts: logical left, logical right and arithmetic right. The count is either the constant 1 or an 8-bit count register. Counts up to 255 are honoured without masking.

A rotate through carry treats the carry as one extra operand bit, so its effective count is taken modulo width+1. A raw count of zero writes the operand back unchanged and leaves every flag alone.

Top module: `rs_unit`

## Requirements
- R1: While `rst_n` is low and after its release, `result`, `wr_en` and all six flag outputs are 0 until the first decoded operation.
- R2: Operation codes on `op_sel` are 0 rotate-left, 1 rotate-right, 2 rotate-left-through-carry, 3 rotate-right-through-carry, 4 shift-left, 5 shift-right-logical and 7 shift-right-arithmetic. `wide`=1 selects 16-bit width and 0 selects 8-bit width. The count is `cnt_reg` when `use_cnt_reg`=1 and 1 otherwise. Results appear on the clock edge after the valid cycle, with `wr_en` high for exactly that cycle.
- R3: A plain rotate by n rotates the operand by n modulo width. For rotate-left, CF becomes result bit 0; for rotate-right, CF becomes the result's sign bit. PF, ZF, SF and AF keep their incoming values.
- R4: A rotate through carry by n rotates the (width+1)-bit value formed by the carry and the operand by n modulo (width+1). For left, the carry sits above the operand; for right, it sits below. The new CF is the bit that lands in the carry position. When the effective count is 0 and the raw count is not, the result equals the operand, CF is unchanged and OF is 0. PF, ZF, SF and AF are kept.
- R5: A logical shift by n at or beyond the width gives zero. CF is the last bit shifted out, and it is 0 when n exceeds the width.
- R6: An arithmetic right shift fills with the sign bit. Counts at or beyond the width give all sign bits, and CF then equals the sign.
- R7: After a shift, ZF is set when the result is zero, SF is the result's sign bit, PF is set on even parity of the low 8 result bits, and AF keeps its incoming value.
- R8: For every operation with a nonzero raw count, OF equals the result's sign bit XOR the operand's sign bit.
- R9: A raw count of 0 on a decoded operation writes the operand back unchanged, with `wr_en` high, and every flag output equals its input.
- R10: A cycle with `in_valid` low, or with `op_sel`=6, gives `wr_en` 0 on the next cycle and leaves `result` and all flags holding their previous values.
- R11: In byte width the upper 8 operand bits are ignored and the upper 8 result bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| wide | input | 1 | 1 = 16-bit operand, 0 = 8-bit operand |
| op_sel | input | 3 | Operation code |
| use_cnt_reg | input | 1 | 1 = count from cnt_reg, 0 = count of 1 |
| cnt_reg | input | 8 | Count register value |
| operand | input | 16 | Destination value before the operation |
| cf_in | input | 1 | Incoming carry flag |
| of_in | input | 1 | Incoming overflow flag |
| pf_in | input | 1 | Incoming parity flag |
| zf_in | input | 1 | Incoming zero flag |
| sf_in | input | 1 | Incoming sign flag |
| af_in | input | 1 | Incoming auxiliary carry flag |
| result | output | 16 | Value to write back |
| wr_en | output | 1 | Write-back strobe, one cycle |
| cf_out | output | 1 | Updated carry flag |
| of_out | output | 1 | Updated overflow flag |
| pf_out | output | 1 | Updated parity flag |
| zf_out | output | 1 | Updated zero flag |
| sf_out | output | 1 | Updated sign flag |
| af_out | output | 1 | Updated auxiliary carry flag |

## Verification
The assertions assume that every input has a known value in each cycle and holds steady across the rising edge that samples it. Their `$past` terms depend on this, since they compare registered outputs against the inputs of the previous cycle. The bench therefore drives all inputs only on the falling edge and gives each of them a defined value from the start of reset. This includes `cnt_reg` and the upper operand byte when they are irrelevant, because byte mode and the constant-1 count must be shown to ignore them.

// File: rtl/rs_pkg.sv
package rs_pkg;

    typedef enum logic [2:0] {
        OP_ROL  = 3'd0,
        OP_ROR  = 3'd1,
        OP_RCL  = 3'd2,
        OP_RCR  = 3'd3,
        OP_SHL  = 3'd4,
        OP_SHR  = 3'd5,
        OP_NONE = 3'd6,
        OP_SAR  = 3'd7
    } rs_op_e;

    typedef struct packed {
        logic cf;
        logic of;
        logic pf;
        logic zf;
        logic sf;
        logic af;
    } rs_flags_t;

    function automatic logic rs_is_rotate(input rs_op_e op);
        return (op == OP_ROL) || (op == OP_ROR) || (op == OP_RCL) || (op == OP_RCR);
    endfunction

endpackage

// File: rtl/rs_count.sv
module rs_count #(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8,
    parameter int CNT_W    = 8,
    localparam int CW      = $clog2(DATA_W + 2)
) (
    input  logic             use_cnt_reg,
    input  logic [CNT_W-1:0] cnt_reg,
    input  logic             wide,
    output logic [CNT_W-1:0] raw_cnt,
    output logic [CW-1:0]    carry_cnt,
    output logic             raw_zero
);
    int span;

    always_comb begin
        raw_cnt   = use_cnt_reg ? cnt_reg : CNT_W'(1);
        raw_zero  = (raw_cnt == '0);
        span      = (wide ? DATA_W : NARROW_W) + 1;
        carry_cnt = CW'(int'(raw_cnt) % span);
    end

endmodule

// File: rtl/rs_rotate.sv
module rs_rotate
    import rs_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8,
    parameter int CNT_W    = 8,
    localparam int CW      = $clog2(DATA_W + 2),
    localparam int IW      = $clog2(DATA_W),
    localparam int EW      = $clog2(DATA_W + 1)
) (
    input  logic [DATA_W-1:0] operand,
    input  logic              wide,
    input  rs_op_e            op,
    input  logic [CNT_W-1:0]  raw_cnt,
    input  logic [CW-1:0]     carry_cnt,
    input  logic              cf_in,
    output logic [DATA_W-1:0] res,
    output logic              cf_out
);
    int          w;
    int          k;
    int          m;
    logic [DATA_W:0] ext;
    logic [DATA_W:0] rot;

    always_comb begin
        w      = wide ? DATA_W : NARROW_W;
        k      = int'(raw_cnt) % w;
        m      = int'(carry_cnt);
        ext    = '0;
        rot    = '0;
        res    = '0;
        cf_out = cf_in;
        case (op)
            OP_ROL: begin
                for (int i = 0; i < DATA_W; i++)
                    if (i < w) res[i] = operand[IW'((i - k + w) % w)];
                cf_out = res[0];
            end
            OP_ROR: begin
                for (int i = 0; i < DATA_W; i++)
                    if (i < w) res[i] = operand[IW'((i + k) % w)];
                cf_out = res[IW'(w - 1)];
            end
            OP_RCL: begin
                // carry is the bit just above the operand
                for (int i = 0; i < DATA_W; i++)
                    if (i < w) ext[i] = operand[i];
                ext[EW'(w)] = cf_in;
                for (int i = 0; i <= DATA_W; i++)
                    if (i <= w) rot[i] = ext[EW'((i - m + w + 1) % (w + 1))];
                for (int i = 0; i < DATA_W; i++)
                    if (i < w) res[i] = rot[i];
                cf_out = rot[EW'(w)];
            end
            OP_RCR: begin
                // carry is the bit just below the operand
                ext[0] = cf_in;
                for (int i = 0; i < DATA_W; i++)
                    if (i < w) ext[i+1] = operand[i];
                for (int i = 0; i <= DATA_W; i++)
                    if (i <= w) rot[i] = ext[EW'((i + m) % (w + 1))];
                for (int i = 0; i < DATA_W; i++)
                    if (i < w) res[i] = rot[i+1];
                cf_out = rot[0];
            end
            default: res = operand;
        endcase
    end

endmodule

// File: rtl/rs_shift.sv
module rs_shift
    import rs_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8,
    parameter int CNT_W    = 8,
    localparam int IW      = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] operand,
    input  logic              wide,
    input  rs_op_e            op,
    input  logic [CNT_W-1:0]  raw_cnt,
    input  logic              cf_in,
    output logic [DATA_W-1:0] res,
    output logic              cf_out
);
    int   w;
    int   n;
    int   last;
    logic sgn;

    always_comb begin
        w      = wide ? DATA_W : NARROW_W;
        n      = int'(raw_cnt);
        sgn    = operand[IW'(w - 1)];
        last   = (n < w) ? n : w;
        res    = '0;
        cf_out = cf_in;
        case (op)
            OP_SHL: begin
                for (int i = 0; i < DATA_W; i++)
                    if (i < w && i >= n) res[i] = operand[IW'(i - n)];
                if (n > 0) cf_out = (n <= w) ? operand[IW'(w - n)] : 1'b0;
            end
            OP_SHR: begin
                for (int i = 0; i < DATA_W; i++)
                    if (i + n < w) res[i] = operand[IW'(i + n)];
                if (n > 0) cf_out = (n <= w) ? operand[IW'(n - 1)] : 1'b0;
            end
            OP_SAR: begin
                for (int i = 0; i < DATA_W; i++)
                    if (i < w) res[i] = (i + n < w) ? operand[IW'(i + n)] : sgn;
                if (n > 0) cf_out = operand[IW'(last - 1)];
            end
            default: res = operand;
        endcase
    end

endmodule

// File: rtl/rs_unit.sv
module rs_unit
    import rs_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8,
    parameter int CNT_W    = 8,
    localparam int CW      = $clog2(DATA_W + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              wide,
    input  logic [2:0]        op_sel,
    input  logic              use_cnt_reg,
    input  logic [CNT_W-1:0]  cnt_reg,
    input  logic [DATA_W-1:0] operand,
    input  logic              cf_in,
    input  logic              of_in,
    input  logic              pf_in,
    input  logic              zf_in,
    input  logic              sf_in,
    input  logic              af_in,
    output logic [DATA_W-1:0] result,
    output logic              wr_en,
    output logic              cf_out,
    output logic              of_out,
    output logic              pf_out,
    output logic              zf_out,
    output logic              sf_out,
    output logic              af_out
);
    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              wr;
        rs_flags_t         fl;
    } rs_state_t;

    rs_state_t         st_d, st_q;
    rs_op_e            op;
    rs_flags_t         fl_in;
    logic [DATA_W-1:0] opnd;
    logic [CNT_W-1:0]  raw_cnt;
    logic [CW-1:0]     carry_cnt;
    logic              raw_zero;
    logic [DATA_W-1:0] rot_res, sh_res;
    logic              rot_cf, sh_cf;
    logic              decoded;

    function automatic logic sign_of(input logic [DATA_W-1:0] x, input logic wd);
        return wd ? x[DATA_W-1] : x[NARROW_W-1];
    endfunction

    assign op      = rs_op_e'(op_sel);
    assign fl_in   = '{cf: cf_in, of: of_in, pf: pf_in, zf: zf_in, sf: sf_in, af: af_in};
    assign opnd    = wide ? operand : {{(DATA_W-NARROW_W){1'b0}}, operand[NARROW_W-1:0]};
    assign decoded = in_valid && (op != OP_NONE);

    rs_count #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .CNT_W(CNT_W)) u_count (
        .use_cnt_reg(use_cnt_reg), .cnt_reg(cnt_reg), .wide(wide),
        .raw_cnt(raw_cnt), .carry_cnt(carry_cnt), .raw_zero(raw_zero)
    );

    rs_rotate #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .CNT_W(CNT_W)) u_rotate (
        .operand(opnd), .wide(wide), .op(op), .raw_cnt(raw_cnt),
        .carry_cnt(carry_cnt), .cf_in(cf_in), .res(rot_res), .cf_out(rot_cf)
    );

    rs_shift #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .CNT_W(CNT_W)) u_shift (
        .operand(opnd), .wide(wide), .op(op), .raw_cnt(raw_cnt),
        .cf_in(cf_in), .res(sh_res), .cf_out(sh_cf)
    );

    always_comb begin
        st_d    = st_q;
        st_d.wr = 1'b0;
        if (decoded) begin
            st_d.wr = 1'b1;
            if (raw_zero) begin
                st_d.res = opnd;
                st_d.fl  = fl_in;
            end else if (rs_is_rotate(op)) begin
                st_d.res   = rot_res;
                st_d.fl    = fl_in;
                st_d.fl.cf = rot_cf;
                st_d.fl.of = sign_of(rot_res, wide) ^ sign_of(opnd, wide);
            end else begin
                st_d.res   = sh_res;
                st_d.fl.cf = sh_cf;
                st_d.fl.of = sign_of(sh_res, wide) ^ sign_of(opnd, wide);
                st_d.fl.pf = ~^sh_res[NARROW_W-1:0];
                st_d.fl.zf = (sh_res == '0);
                st_d.fl.sf = sign_of(sh_res, wide);
                st_d.fl.af = af_in;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result = st_q.res;
    assign wr_en  = st_q.wr;
    assign cf_out = st_q.fl.cf;
    assign of_out = st_q.fl.of;
    assign pf_out = st_q.fl.pf;
    assign zf_out = st_q.fl.zf;
    assign sf_out = st_q.fl.sf;
    assign af_out = st_q.fl.af;

    // idle or undecoded cycles hold every output
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !decoded |=> !wr_en && $stable(result) && $stable({cf_out, of_out, pf_out, zf_out, sf_out, af_out}));

    // zero raw count writes back the operand, flags untouched
    p_zero_cnt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        decoded && raw_zero |=> wr_en && result == $past(opnd)
            && {cf_out, of_out, pf_out, zf_out, sf_out, af_out} == $past(fl_in));

    // rotates keep the four non-carry status flags
    p_rot_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        decoded && rs_is_rotate(op) |=> {pf_out, zf_out, sf_out, af_out} == $past({pf_in, zf_in, sf_in, af_in}));

    // OF is the sign change between operand and result
    p_of_sign_r8: assert property (@(posedge clk) disable iff (!rst_n)
        decoded && !raw_zero |=> of_out == (sign_of(result, $past(wide)) ^ $past(sign_of(opnd, wide))));

    // byte results never carry data in the upper byte
    p_byte_hi_r11: assert property (@(posedge clk) disable iff (!rst_n)
        decoded && !wide |=> result[DATA_W-1:NARROW_W] == '0);

    // logical shifts past the width give zero
    p_shift_big_r5: assert property (@(posedge clk) disable iff (!rst_n)
        decoded && (op == OP_SHL || op == OP_SHR) && int'(raw_cnt) >= (wide ? DATA_W : NARROW_W)
        |=> result == '0);

endmodule

// File: tb/tb_rs_unit.sv
module tb_rs_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYCLES = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        wide = 1'b0;
    logic [2:0]  op_sel = 3'd0;
    logic        use_cnt_reg = 1'b0;
    logic [7:0]  cnt_reg = 8'd0;
    logic [15:0] operand = 16'd0;
    logic        cf_in = 1'b0, of_in = 1'b0, pf_in = 1'b0, zf_in = 1'b0, sf_in = 1'b0, af_in = 1'b0;
    logic [15:0] result;
    logic        wr_en, cf_out, of_out, pf_out, zf_out, sf_out, af_out;

    rs_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .wide(wide), .op_sel(op_sel),
        .use_cnt_reg(use_cnt_reg), .cnt_reg(cnt_reg), .operand(operand),
        .cf_in(cf_in), .of_in(of_in), .pf_in(pf_in), .zf_in(zf_in), .sf_in(sf_in), .af_in(af_in),
        .result(result), .wr_en(wr_en), .cf_out(cf_out), .of_out(of_out), .pf_out(pf_out),
        .zf_out(zf_out), .sf_out(sf_out), .af_out(af_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic [15:0] res;
        logic        wr;
        logic [5:0]  fl;   // {cf, of, pf, zf, sf, af}
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    failures = 0;
    bit    finished = 1'b0;

    logic [15:0] held_res = 16'd0;
    logic [5:0]  held_fl  = 6'd0;

    function automatic string tag_for(input int op);
        case (op)
            0, 1:    return "R3";
            2, 3:    return "R4";
            4, 5:    return "R5";
            7:       return "R6";
            default: return "R10";
        endcase
    endfunction

    // driver: applies one cycle of stimulus and queues what must follow it
    task automatic drive(input bit vld, input bit wd, input int op, input bit use_reg,
                         input int cnt, input logic [15:0] val, input logic [5:0] fin, input string tag);
        int          w;
        int          n;
        logic [15:0] mask, v, v0;
        logic        c, b, sg;
        exp_t        e;
        @(negedge clk);
        in_valid = vld; wide = wd; op_sel = 3'(op); use_cnt_reg = use_reg;
        cnt_reg = 8'(cnt); operand = val;
        {cf_in, of_in, pf_in, zf_in, sf_in, af_in} = fin;
        w    = wd ? 16 : 8;
        mask = wd ? 16'hFFFF : 16'h00FF;
        v    = val & mask;
        v0   = v;
        n    = use_reg ? cnt : 1;
        c    = fin[5];
        if (vld && op != 6) begin
            for (int it = 0; it < n; it++) begin
                sg = v[w-1];
                case (op)
                    0: begin b = v[w-1]; v = ((v << 1) | 16'(b)) & mask; c = b; end
                    1: begin b = v[0]; v = (v >> 1) | (16'(b) << (w-1)); c = b; end
                    2: begin b = v[w-1]; v = ((v << 1) | 16'(c)) & mask; c = b; end
                    3: begin b = v[0]; v = (v >> 1) | (16'(c) << (w-1)); c = b; end
                    4: begin c = v[w-1]; v = (v << 1) & mask; end
                    5: begin c = v[0]; v = v >> 1; end
                    default: begin c = v[0]; v = (v >> 1) | (16'(sg) << (w-1)); end
                endcase
            end
            held_res = v;
            if (n == 0) held_fl = fin;
            else if (op <= 3) held_fl = {c, v[w-1] ^ v0[w-1], fin[3:0]};
            else held_fl = {c, v[w-1] ^ v0[w-1], ~^v[7:0], v == 16'd0, v[w-1], fin[0]};
            e.wr = 1'b1;
        end else begin
            e.wr = 1'b0;
        end
        e.res = held_res;
        e.fl  = held_fl;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // monitor: compares one queued item per cycle after the edge that produced it
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t  e;
                exp_t  got;
                string t;
                e   = exp_q.pop_front();
                t   = tag_q.pop_front();
                got = {result, wr_en, cf_out, of_out, pf_out, zf_out, sf_out, af_out};
                checks++;
                if (got !== e) begin
                    failures++;
                    $display("FAIL %s got res=%h wr=%b fl=%b expected res=%h wr=%b fl=%b",
                             t, got.res, got.wr, got.fl, e.res, e.wr, e.fl);
                end
            end
        end
    end

    initial begin
        repeat (WDOG_CYCLES) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    logic [15:0] pats [6] = '{16'h8001, 16'h00FF, 16'hA5C3, 16'h7F80, 16'h0000, 16'hFFFF};

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs idle during reset
        checks++;
        if ({result, wr_en, cf_out, of_out, pf_out, zf_out, sf_out, af_out} !== '0) begin
            failures++;
            $display("FAIL R1 got %h expected 0", {result, wr_en, cf_out, of_out, pf_out, zf_out, sf_out, af_out});
        end
        rst_n = 1'b1;
        drive(1'b0, 1'b0, 0, 1'b0, 0, 16'h0000, 6'b0, "R1");

        // R2: constant-1 count ignores cnt_reg; byte and word width
        drive(1'b1, 1'b0, 0, 1'b0, 200, 16'h5581, 6'b000000, "R2");
        drive(1'b1, 1'b1, 1, 1'b1, 4, 16'h1234, 6'b011110, "R2");
        drive(1'b0, 1'b1, 1, 1'b1, 4, 16'h1234, 6'b011110, "R2");
        // R3: rotates preserve PF/ZF/SF/AF
        drive(1'b1, 1'b1, 0, 1'b1, 19, 16'h8001, 6'b101111, "R3");
        drive(1'b1, 1'b0, 1, 1'b1, 11, 16'h0081, 6'b010101, "R3");
        // R4: carry-through modulo width+1, including effective zero
        drive(1'b1, 1'b0, 2, 1'b1, 9, 16'h00C3, 6'b110000, "R4");
        drive(1'b1, 1'b1, 3, 1'b1, 17, 16'h8001, 6'b010000, "R4");
        drive(1'b1, 1'b1, 2, 1'b1, 20, 16'hB00F, 6'b100000, "R4");
        drive(1'b1, 1'b0, 3, 1'b1, 1, 16'h0001, 6'b100000, "R4");
        // R5: logical shifts at and beyond width
        drive(1'b1, 1'b0, 4, 1'b1, 8, 16'h0001, 6'b000000, "R5");
        drive(1'b1, 1'b0, 4, 1'b1, 9, 16'h00FF, 6'b100000, "R5");
        drive(1'b1, 1'b1, 5, 1'b1, 16, 16'h8000, 6'b000000, "R5");
        drive(1'b1, 1'b1, 5, 1'b1, 200, 16'hFFFF, 6'b100000, "R5");
        // R6: arithmetic shift saturates to sign
        drive(1'b1, 1'b0, 7, 1'b1, 3, 16'h0080, 6'b000000, "R6");
        drive(1'b1, 1'b1, 7, 1'b1, 255, 16'h8000, 6'b000000, "R6");
        drive(1'b1, 1'b1, 7, 1'b1, 255, 16'h7FFF, 6'b100000, "R6");
        // R7: ZF/SF/PF from result, AF kept
        drive(1'b1, 1'b0, 5, 1'b0, 0, 16'h0001, 6'b000001, "R7");
        drive(1'b1, 1'b1, 4, 1'b1, 4, 16'h0F03, 6'b001110, "R7");
        // R8: OF sign change on a shift by one
        drive(1'b1, 1'b0, 4, 1'b0, 0, 16'h0040, 6'b000000, "R8");
        // R9: zero raw count leaves everything
        drive(1'b1, 1'b1, 2, 1'b1, 0, 16'hDEAD, 6'b110101, "R9");
        drive(1'b1, 1'b0, 7, 1'b1, 0, 16'hBEEF, 6'b011010, "R9");
        // R10: undecoded code and idle cycles hold outputs
        drive(1'b1, 1'b1, 6, 1'b1, 3, 16'h1111, 6'b111111, "R10");
        drive(1'b0, 1'b0, 4, 1'b1, 1, 16'h2222, 6'b000000, "R10");
        // R11: upper operand byte ignored in byte width
        drive(1'b1, 1'b0, 1, 1'b1, 3, 16'hFF18, 6'b000000, "R11");
        drive(1'b1, 1'b0, 7, 1'b1, 2, 16'hAA80, 6'b000000, "R11");

        // sweep every operation, width and several counts
        for (int op = 0; op < 8; op++) begin
            for (int p = 0; p < 6; p++) begin
                for (int ci = 0; ci < 6; ci++) begin
                    int cnts [6] = '{1, 5, 8, 9, 16, 33};
                    drive(1'b1, (p + ci) % 2 == 1, op, 1'b1, cnts[ci], pats[p],
                          6'(p * 11 + ci), tag_for(op));
                end
            end
        end

        drive(1'b0, 1'b0, 0, 1'b0, 0, 16'h0, 6'b0, "R10");
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule